// File: doc/BRIEF.md
# Banked Register File Address Resolver

This block turns the data-memory operand of an 8-bit microcontroller instruction into one physical register-file address. The data space is 9 bits wide and split into four 128-byte banks. A direct access joins the 7-bit operand offset from the instruction with two bank-select bits. An access to offset 00h in any bank is an indirect access. Its 9-bit address is the 8-bit pointer register with a separate indirect bank bit above it, and the direct bank bits play no part in it.

After the address is formed, locations that are mirrored across banks are folded onto one cell. The pointer-low, status and pointer registers at offsets 02h, 03h and 04h, and the common RAM window at 70h–7Fh, always resolve to bank 0. The block then classifies the resolved address as special-function register, general-purpose RAM, or a "zero" location. A zero location reads as 00h and ignores writes. The result is registered, so the outputs follow an access strobe by one clock.

Top module: `bank_addr_top`

## Requirements
- R1: A direct access (nonzero offset) uses effective address {bank_sel_i, dir_off_i}.
- R2: An access with dir_off_i == 00h is indirect. Its effective address is {ind_bank_i, ptr_i}, ind_o is 1, and bank_sel_i is ignored.
- R3: An indirect access whose pointer offset (ptr_i[6:0]) is 00h is a zero location: zero_rd_o=1, ram_addr_o=000h, no select, and wr_en_o stays 0.
- R4: Offsets 02h, 03h and 04h in any bank resolve to 002h, 003h and 004h and assert sfr_sel_o.
- R5: Offsets 70h–7Fh in any bank resolve to 070h–07Fh and assert gpr_sel_o.
- R6: The other offsets 01h–1Fh assert sfr_sel_o at the effective address, except that offsets 10h–1Fh in banks 2 and 3 are unimplemented zero locations (zero_rd_o=1, address 000h, no write).
- R7: Offsets 20h–6Fh assert gpr_sel_o at the effective address.
- R8: Outputs are registered and reflect the access presented on the previous clock edge. A cycle without acc_i gives address 000h and all strobes low.
- R9: While rst_ni is low, all outputs are 0.
- R10: wr_en_o equals wr_i for an access that selects an SFR or GPR, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_i | input | 1 | Access strobe |
| wr_i | input | 1 | Access is a write |
| dir_off_i | input | 7 | Operand offset from the instruction |
| bank_sel_i | input | 2 | Direct bank-select bits |
| ind_bank_i | input | 1 | Ninth address bit for indirect access |
| ptr_i | input | 8 | Indirect pointer register |
| ram_addr_o | output | 9 | Resolved physical address |
| sfr_sel_o | output | 1 | Special-function register selected |
| gpr_sel_o | output | 1 | General-purpose RAM selected |
| zero_rd_o | output | 1 | Location reads 00h, writes dropped |
| wr_en_o | output | 1 | Write strobe to the selected target |
| ind_o | output | 1 | Access was indirect |

## Verification
The assertions check properties that hold on every cycle. At most one of the three classification strobes is high. A write strobe never appears without an SFR or GPR select. A zero location always carries address 000h. Any select or offset in the shared or common ranges lands in bank 0. Idle cycles leave every strobe low. The exact address for each bank, offset and mode combination can only be shown by the bench's directed scenarios. This covers mirroring, the indirect bank bit overriding the direct bits, the self-pointing pointer, and the unimplemented upper-bank SFR holes.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;
  localparam int ADDR_W = 9;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_SFR  = 2'd1,
    TGT_GPR  = 2'd2,
    TGT_ZERO = 2'd3
  } tgt_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    tgt_e              tgt;
    logic              ind;
  } res_t;
endpackage

// File: rtl/bank_addr_mux.sv
module bank_addr_mux #(
  parameter int OFF_W  = 7,
  parameter int BANK_W = 2,
  localparam int ADDR_W = OFF_W + BANK_W,
  localparam int PTR_W  = OFF_W + 1
) (
  input  logic [OFF_W-1:0]  dir_off_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic              ind_bank_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic              ind_o
);
  // offset zero is the indirect-access pseudo register
  assign ind_o      = (dir_off_i == '0);
  assign eff_addr_o = ind_o ? {ind_bank_i, ptr_i} : {bank_sel_i, dir_off_i};

  always_comb begin
    if (!ind_o) assert (eff_addr_o[OFF_W-1:0] != '0); // R1: direct never hits offset 0
  end
endmodule

// File: rtl/bank_mirror_map.sv
module bank_mirror_map
  import bank_addr_pkg::*;
#(
  parameter int OFF_W = 7,
  parameter logic [OFF_W-1:0] SFR_TOP     = 7'h20,
  parameter logic [OFF_W-1:0] HOLE_LO     = 7'h10,
  parameter logic [OFF_W-1:0] COMMON_BASE = 7'h70,
  parameter logic [OFF_W-1:0] SHARED_LO   = 7'h02,
  parameter logic [OFF_W-1:0] SHARED_HI   = 7'h04,
  localparam int BANK_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] eff_addr_i,
  input  logic              ind_i,
  output res_t              res_o
);
  logic [OFF_W-1:0]  off;
  logic [BANK_W-1:0] bank;

  assign off  = eff_addr_i[OFF_W-1:0];
  assign bank = eff_addr_i[ADDR_W-1:OFF_W];

  always_comb begin
    res_o.ind  = ind_i;
    res_o.addr = eff_addr_i;
    res_o.tgt  = TGT_GPR;
    if (off == '0) begin
      res_o.tgt  = TGT_ZERO;
      res_o.addr = '0;
    end else if (off >= SHARED_LO && off <= SHARED_HI) begin
      res_o.tgt  = TGT_SFR;
      res_o.addr = {{BANK_W{1'b0}}, off};
    end else if (off >= COMMON_BASE) begin
      res_o.tgt  = TGT_GPR;
      res_o.addr = {{BANK_W{1'b0}}, off};
    end else if (off < SFR_TOP) begin
      if (bank[BANK_W-1] && off >= HOLE_LO) begin
        res_o.tgt  = TGT_ZERO;
        res_o.addr = '0;
      end else begin
        res_o.tgt  = TGT_SFR;
      end
    end
  end

  always_comb begin
    if (res_o.tgt == TGT_ZERO) assert (res_o.addr == '0); // R3 R6
  end
endmodule

// File: rtl/bank_addr_top.sv
module bank_addr_top
  import bank_addr_pkg::*;
#(
  parameter int OFF_W  = 7,
  parameter int BANK_W = 2,
  localparam int AW    = OFF_W + BANK_W,
  localparam int PW    = OFF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  dir_off_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic              ind_bank_i,
  input  logic [PW-1:0]     ptr_i,
  output logic [AW-1:0]     ram_addr_o,
  output logic              sfr_sel_o,
  output logic              gpr_sel_o,
  output logic              zero_rd_o,
  output logic              wr_en_o,
  output logic              ind_o
);
  logic [AW-1:0] eff_addr;
  logic          ind;
  res_t          res;

  bank_addr_mux #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_mux (
    .dir_off_i (dir_off_i),
    .bank_sel_i(bank_sel_i),
    .ind_bank_i(ind_bank_i),
    .ptr_i     (ptr_i),
    .eff_addr_o(eff_addr),
    .ind_o     (ind)
  );

  bank_mirror_map #(.OFF_W(OFF_W)) u_map (
    .eff_addr_i(eff_addr),
    .ind_i     (ind),
    .res_o     (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_addr_o <= '0;
      sfr_sel_o  <= 1'b0;
      gpr_sel_o  <= 1'b0;
      zero_rd_o  <= 1'b0;
      wr_en_o    <= 1'b0;
      ind_o      <= 1'b0;
    end else if (acc_i) begin
      ram_addr_o <= res.addr;
      sfr_sel_o  <= (res.tgt == TGT_SFR);
      gpr_sel_o  <= (res.tgt == TGT_GPR);
      zero_rd_o  <= (res.tgt == TGT_ZERO);
      wr_en_o    <= wr_i && (res.tgt == TGT_SFR || res.tgt == TGT_GPR);
      ind_o      <= res.ind;
    end else begin
      ram_addr_o <= '0;
      sfr_sel_o  <= 1'b0;
      gpr_sel_o  <= 1'b0;
      zero_rd_o  <= 1'b0;
      wr_en_o    <= 1'b0;
      ind_o      <= 1'b0;
    end
  end

  p_one_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sfr_sel_o, gpr_sel_o, zero_rd_o}));
  p_wr_needs_sel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (sfr_sel_o || gpr_sel_o));
  p_zero_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_rd_o |-> (!wr_en_o && ram_addr_o == '0));
  p_common_bank0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpr_sel_o && ram_addr_o[OFF_W-1:OFF_W-3] == 3'b111) |-> ram_addr_o[AW-1:OFF_W] == '0);
  p_shared_bank0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_sel_o && ram_addr_o[OFF_W-1:0] >= 7'h02 && ram_addr_o[OFF_W-1:0] <= 7'h04)
      |-> ram_addr_o[AW-1:OFF_W] == '0);
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> !(sfr_sel_o || gpr_sel_o || zero_rd_o || wr_en_o || ind_o));
  p_indirect_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && dir_off_i == '0) |=> ind_o);
endmodule

// File: tb/bank_addr_top_bench.sv
module bank_addr_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       acc_i = 1'b0, wr_i = 1'b0, ind_bank_i = 1'b0;
  logic [6:0] dir_off_i = '0;
  logic [1:0] bank_sel_i = '0;
  logic [7:0] ptr_i = '0;
  logic [8:0] ram_addr_o;
  logic       sfr_sel_o, gpr_sel_o, zero_rd_o, wr_en_o, ind_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bank_addr_top u_bank_addr_top (
    .clk_i, .rst_ni, .acc_i, .wr_i, .dir_off_i, .bank_sel_i, .ind_bank_i, .ptr_i,
    .ram_addr_o, .sfr_sel_o, .gpr_sel_o, .zero_rd_o, .wr_en_o, .ind_o
  );

  // packed {addr, sfr, gpr, zero, wr_en, ind}
  task automatic expect_out(string req, logic [8:0] a, logic s, logic g, logic z, logic w, logic i);
    logic [13:0] act, exp;
    act = {ram_addr_o, sfr_sel_o, gpr_sel_o, zero_rd_o, wr_en_o, ind_o};
    exp = {a, s, g, z, w, i};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(logic [1:0] bk, logic [6:0] off, logic ib, logic [7:0] p, logic w);
    @(negedge clk_i);
    acc_i = 1'b1; wr_i = w; bank_sel_i = bk; dir_off_i = off; ind_bank_i = ib; ptr_i = p;
    @(negedge clk_i);
    acc_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic t_reset;
    expect_out("R9", 9'h000, 0, 0, 0, 0, 0);
  endtask

  task automatic t_direct;
    access(2'd1, 7'h25, 0, 8'h00, 0); expect_out("R1 R7", 9'h0A5, 0, 1, 0, 0, 0);
    access(2'd1, 7'h01, 0, 8'h00, 0); expect_out("R1 R6", 9'h081, 1, 0, 0, 0, 0);
    access(2'd1, 7'h15, 0, 8'h00, 1); expect_out("R6", 9'h095, 1, 0, 0, 1, 0);
    access(2'd3, 7'h6F, 0, 8'h00, 0); expect_out("R7", 9'h1EF, 0, 1, 0, 0, 0);
  endtask

  task automatic t_mirror;
    access(2'd3, 7'h03, 0, 8'h00, 0); expect_out("R4", 9'h003, 1, 0, 0, 0, 0);
    access(2'd2, 7'h04, 0, 8'h00, 1); expect_out("R4", 9'h004, 1, 0, 0, 1, 0);
    access(2'd2, 7'h7A, 0, 8'h00, 0); expect_out("R5", 9'h07A, 0, 1, 0, 0, 0);
    access(2'd3, 7'h70, 0, 8'h00, 1); expect_out("R5", 9'h070, 0, 1, 0, 1, 0);
  endtask

  task automatic t_indirect;
    access(2'd0, 7'h00, 1, 8'h30, 0); expect_out("R2", 9'h130, 0, 1, 0, 0, 1);
    access(2'd3, 7'h00, 0, 8'h45, 1); expect_out("R2", 9'h045, 0, 1, 0, 1, 1);
    access(2'd0, 7'h00, 1, 8'h83, 0); expect_out("R2 R4", 9'h003, 1, 0, 0, 0, 1);
    access(2'd0, 7'h00, 1, 8'h80, 1); expect_out("R3", 9'h000, 0, 0, 1, 0, 1);
    access(2'd2, 7'h00, 0, 8'h00, 1); expect_out("R3", 9'h000, 0, 0, 1, 0, 1);
  endtask

  task automatic t_holes;
    access(2'd2, 7'h15, 0, 8'h00, 1); expect_out("R6", 9'h000, 0, 0, 1, 0, 0);
    access(2'd3, 7'h10, 0, 8'h00, 0); expect_out("R6", 9'h000, 0, 0, 1, 0, 0);
    access(2'd2, 7'h0F, 0, 8'h00, 0); expect_out("R6", 9'h10F, 1, 0, 0, 0, 0);
  endtask

  task automatic t_write_idle;
    access(2'd0, 7'h40, 0, 8'h00, 1); expect_out("R10", 9'h040, 0, 1, 0, 1, 0);
    @(negedge clk_i); expect_out("R8", 9'h000, 0, 0, 0, 0, 0);
    @(negedge clk_i);
    acc_i = 1'b1; wr_i = 1'b1; bank_sel_i = 2'd0; dir_off_i = 7'h21;
    #1 expect_out("R8", 9'h000, 0, 0, 0, 0, 0);
    @(negedge clk_i); expect_out("R8 R10", 9'h021, 0, 1, 0, 1, 0);
    acc_i = 1'b0; wr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 2.5);
    t_reset();
    rst_ni = 1'b1;
    t_direct();
    t_mirror();
    t_indirect();
    t_holes();
    t_write_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 5000);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule